// File: doc/BRIEF.md
# Timer Output Compare Unit

An 8-bit timer/counter with one output compare channel. A CPU-side write port loads the counter and the compare value, and a timer clock enable (`tick`) advances the count. A two-bit waveform mode selects one of four counting sequences: free-running wrap, clear-on-match, fast PWM and phase-correct PWM. An equality comparator watches the counter against the active compare value. It raises a compare flag, which can also request an interrupt, and it drives a waveform output according to a two-bit pin action field. An overflow flag marks the end of each counting period.

In the two PWM modes the compare value is double-buffered. A CPU write lands in a holding register, and that register is copied into the active compare value only at a fixed point in the period. This keeps every PWM pulse whole and symmetric. In the two non-PWM modes a write reaches the active compare value directly. The direction of the count is kept by a small state machine with two states. `ST_UP` counts upward. `ST_DOWN` is entered only in phase-correct mode: the `UP_TO_DOWN` transition occurs on a step at 0xFF, and the `DOWN_TO_UP` transition occurs on a step at 0x00. In any other mode the machine is forced back to `ST_UP`.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After reset the count, the active compare value, the holding register, both flags and the waveform register are 0, and the direction state is `ST_UP`.
- R2: A step is a cycle with `tick`=1 and `cnt_we`=0, and the counter changes only on a step. The mode field is encoded as follows. 00 is normal mode: the counter increments and wraps from 0xFF to 0x00. 01 is phase-correct mode: the counter counts up to 0xFF, continues at 0xFE going down, and continues at 0x01 going up after reaching 0x00. 10 is clear-on-match mode: the counter goes to 0x00 on a step where it equals the active compare value, and otherwise increments. 11 is fast PWM mode and counts like mode 00.
- R3: When `cnt_we`=1, the counter takes `cnt_wdata` at the next edge, whatever the value of `tick`. In that cycle there is no count step and no flag, buffer or waveform event.
- R4: The compare flag is set at the end of a step in which the count equals the active compare value. It is therefore visible one cycle later, never in the same cycle. When a set and a clear happen together, the set wins.
- R5: A `flag_wr` cycle with `flag_wdata[0]`=1 clears the compare flag, and one with `flag_wdata[1]`=1 clears the overflow flag. A 0 in either bit leaves that flag unchanged. An `ack` pulse clears the compare flag.
- R6: `irq` equals the compare flag ANDed with `irq_en`.
- R7: The overflow flag is set at the end of a step taken at 0xFF in modes 00, 10 and 11. In mode 01 it is set at the end of a step taken at 0x00 while in `ST_DOWN`.
- R8: In modes 00 and 10, a `cmp_wdata` write reaches `cmp_act` at the next edge. In modes 01 and 11 the write goes only to the holding register. That register is copied into `cmp_act` in two cases: on a step at 0xFF in mode 11 (the wrap to bottom), and on a step at 0xFF in `ST_UP` in mode 01 (top). A write in the same cycle as a copy is not part of that copy.
- R9: `at_bottom` is 1 exactly when the count is 0x00. `at_top` is 1 when the count equals `cmp_act` in mode 10, and when the count is 0xFF in every other mode.
- R10: In modes 00 and 10, a step on a match acts on the waveform register according to the pin action field. Action 01 toggles it, 10 clears it and 11 sets it.
- R11: In mode 11, action 10 sets the waveform register on a step at 0xFF and otherwise clears it on a step at a match. Action 11 does the opposite. The action at 0xFF wins when both apply.
- R12: In mode 01, action 10 clears the waveform register on a match in `ST_UP` and sets it on a match in `ST_DOWN`. Action 11 does the reverse.
- R13: `wave_out` is 0 when the pin action is 00, and also when it is 01 in mode 01 or 11. Otherwise it shows the waveform register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare value write data |
| flag_wr | input | 1 | Flag write strobe; writing a 1 clears that flag |
| flag_wdata | input | 2 | Bit 0 selects the compare flag, bit 1 the overflow flag |
| ack | input | 1 | Interrupt acknowledge; clears the compare flag |
| irq_en | input | 1 | Compare interrupt enable |
| mode | input | 2 | Counting mode (00 normal, 01 phase-correct, 10 clear-on-match, 11 fast PWM) |
| out_mode | input | 2 | Pin action (00 off, 01 toggle, 10 clear, 11 set) |
| count | output | 8 | Counter value |
| cmp_act | output | 8 | Active compare value |
| cmp_flag | output | 1 | Compare-match flag |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Compare interrupt request |
| wave_out | output | 1 | Waveform pin |
| at_top | output | 1 | Count is at the top of the sequence |
| at_bottom | output | 1 | Count is 0x00 |

## Verification
The bench sweeps every mode and every pin action against compare values of 0x00, 0x01, 0x7F, 0xFE and 0xFF, with the clock enable either always on or gated. A design that set the compare flag in the matching cycle itself, or on a non-step cycle, would show the flag one cycle early. A design that copied the holding register at the wrong end of the period would show a stale `cmp_act` and a shortened pulse just after a mid-run compare write. The compare values 0x00 and 0xFF put the match on top of the wrap point and the turn-around points, which exposes a wrong priority between the match action and the bottom action, or a phase-correct counter that stays one extra cycle at an end. Counter writes that collide with an active `tick`, and writes of 0 to the flag bits, show whether write priority and write-one-to-clear hold.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MD_NORMAL = 2'b00,
        MD_PHASE  = 2'b01,
        MD_CTC    = 2'b10,
        MD_FAST   = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_CLEAR  = 2'b10,
        OM_SET    = 2'b11
    } out_mode_e;

    typedef enum logic {
        ST_UP   = 1'b0,
        ST_DOWN = 1'b1
    } dir_state_e;

    function automatic logic is_pwm(input tmr_mode_e m);
        return (m == MD_PHASE) || (m == MD_FAST);
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    input  tmr_mode_e    mode,
    input  logic         match,
    output logic [W-1:0] count,
    output dir_state_e   dir
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    dir_state_e   state_q, state_d;
    logic [W-1:0] count_q, count_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UP;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        if (cnt_we) begin
            count_d = cnt_wdata;
        end else if (step) begin
            unique case (mode)
                MD_NORMAL, MD_FAST: count_d = count_q + ONE;
                MD_CTC:             count_d = match ? '0 : count_q + ONE;
                MD_PHASE: begin
                    unique case (state_q)
                        ST_UP: begin
                            if (count_q == MAXV) begin
                                count_d = MAXV - ONE;
                                state_d = ST_DOWN;   // UP_TO_DOWN
                            end else begin
                                count_d = count_q + ONE;
                            end
                        end
                        ST_DOWN: begin
                            if (count_q == '0) begin
                                count_d = ONE;
                                state_d = ST_UP;     // DOWN_TO_UP
                            end else begin
                                count_d = count_q - ONE;
                            end
                        end
                    endcase
                end
            endcase
        end
        if (mode != MD_PHASE) state_d = ST_UP;
    end

    assign count = count_q;
    assign dir   = state_q;
endmodule

// File: rtl/tmr_cmp_reg.sv
module tmr_cmp_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         pwm,
    input  logic         load,
    output logic [W-1:0] cmp_act
);
    logic [W-1:0] hold_q, act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            if (cmp_we) hold_q <= cmp_wdata;
            if (!pwm && cmp_we)   act_q <= cmp_wdata;
            else if (pwm && load) act_q <= hold_q;
        end
    end

    assign cmp_act = act_q;
endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  tmr_mode_e  mode,
    input  out_mode_e  omode,
    input  logic       match,
    input  logic       at_max,
    input  dir_state_e dir,
    output logic       wave_out
);
    logic wave_q, wave_d, pin_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    always_comb begin
        wave_d = wave_q;
        if (step) begin
            unique case (mode)
                MD_NORMAL, MD_CTC: begin
                    if (match) begin
                        unique case (omode)
                            OM_TOGGLE: wave_d = ~wave_q;
                            OM_CLEAR:  wave_d = 1'b0;
                            OM_SET:    wave_d = 1'b1;
                            default:   wave_d = wave_q;
                        endcase
                    end
                end
                MD_FAST: begin
                    if (omode == OM_CLEAR)
                        wave_d = at_max ? 1'b1 : (match ? 1'b0 : wave_q);
                    else if (omode == OM_SET)
                        wave_d = at_max ? 1'b0 : (match ? 1'b1 : wave_q);
                end
                MD_PHASE: begin
                    if (match && omode == OM_CLEAR) wave_d = (dir == ST_DOWN);
                    else if (match && omode == OM_SET) wave_d = (dir == ST_UP);
                end
            endcase
        end
    end

    assign pin_on   = (omode != OM_OFF) && !(is_pwm(mode) && omode == OM_TOGGLE);
    assign wave_out = pin_on & wave_q;
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         flag_wr,
    input  logic [1:0]   flag_wdata,
    input  logic         ack,
    input  logic         irq_en,
    input  logic [1:0]   mode,
    input  logic [1:0]   out_mode,
    output logic [W-1:0] count,
    output logic [W-1:0] cmp_act,
    output logic         cmp_flag,
    output logic         ovf_flag,
    output logic         irq,
    output logic         wave_out,
    output logic         at_top,
    output logic         at_bottom
);
    localparam logic [W-1:0] MAXV = '1;

    tmr_mode_e  mode_e;
    out_mode_e  omode_e;
    dir_state_e dir;
    logic step, match, at_max, at_zero, ovf_evt, load;
    logic cflag_q, oflag_q;

    assign mode_e  = tmr_mode_e'(mode);
    assign omode_e = out_mode_e'(out_mode);
    assign step    = tick && !cnt_we;
    assign match   = (count == cmp_act);
    assign at_max  = (count == MAXV);
    assign at_zero = (count == '0);

    assign ovf_evt = step && ((mode_e == MD_PHASE) ? (dir == ST_DOWN && at_zero) : at_max);
    assign load    = step && at_max &&
                     ((mode_e == MD_FAST) || (mode_e == MD_PHASE && dir == ST_UP));

    tmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step), .cnt_we(cnt_we),
        .cnt_wdata(cnt_wdata), .mode(mode_e), .match(match),
        .count(count), .dir(dir)
    );

    tmr_cmp_reg #(.W(W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .pwm(is_pwm(mode_e)), .load(load), .cmp_act(cmp_act)
    );

    tmr_wavegen u_wave (
        .clk(clk), .rst_n(rst_n), .step(step), .mode(mode_e), .omode(omode_e),
        .match(match), .at_max(at_max), .dir(dir), .wave_out(wave_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cflag_q <= 1'b0;
            oflag_q <= 1'b0;
        end else begin
            if (step && match)                       cflag_q <= 1'b1;
            else if (ack || (flag_wr && flag_wdata[0])) cflag_q <= 1'b0;
            if (ovf_evt)                             oflag_q <= 1'b1;
            else if (flag_wr && flag_wdata[1])       oflag_q <= 1'b0;
        end
    end

    assign cmp_flag  = cflag_q;
    assign ovf_flag  = oflag_q;
    assign irq       = cflag_q & irq_en;
    assign at_top    = (mode_e == MD_CTC) ? match : at_max;
    assign at_bottom = at_zero;
endmodule

// File: rtl/tmr_cmp_unit_chk.sv
module tmr_cmp_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         cnt_we,
    input logic [W-1:0] cnt_wdata,
    input logic         cmp_we,
    input logic [W-1:0] cmp_wdata,
    input logic         ack,
    input logic         irq_en,
    input logic [1:0]   mode,
    input logic [1:0]   out_mode,
    input logic [W-1:0] count,
    input logic [W-1:0] cmp_act,
    input logic         cmp_flag,
    input logic         ovf_flag,
    input logic         irq,
    input logic         wave_out
);
    assert_hold_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_we) |=> $stable(count));

    assert_cnt_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (count == $past(cnt_wdata)));

    assert_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> $past(tick && !cnt_we && (count == cmp_act)));

    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !(tick && !cnt_we && (count == cmp_act))) |=> !cmp_flag);

    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_ovf_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(tick && !cnt_we));

    assert_direct_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we && !mode[0]) |=> (cmp_act == $past(cmp_wdata)));

    assert_pin_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'b00) |-> !wave_out);
endmodule

bind tmr_cmp_unit tmr_cmp_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_tmr_cmp_unit.sv
module tb_tmr_cmp_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, cnt_we = 1'b0, cmp_we = 1'b0, flag_wr = 1'b0, ack = 1'b0, irq_en = 1'b0;
    logic [7:0] cnt_wdata = '0, cmp_wdata = '0;
    logic [1:0] flag_wdata = '0, mode = '0, out_mode = '0;
    logic [7:0] count, cmp_act;
    logic       cmp_flag, ovf_flag, irq, wave_out, at_top, at_bottom;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    tmr_cmp_unit dut (.*);

    // ---------- reference model built from the requirements ----------
    logic [7:0] m_cnt = '0, m_act = '0, m_hold = '0;
    logic       m_down = 1'b0, m_cf = 1'b0, m_of = 1'b0, m_wave = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        logic [7:0] n_cnt, n_act, n_hold;
        logic n_down, n_cf, n_of, n_wave, stp, mt, amax, zero, pwm, ld, ev;
        if (!rst_n) begin
            m_cnt = '0; m_act = '0; m_hold = '0;
            m_down = 1'b0; m_cf = 1'b0; m_of = 1'b0; m_wave = 1'b0;
        end else begin
            stp  = tick && !cnt_we;
            mt   = (m_cnt == m_act);
            amax = (m_cnt == 8'hFF);
            zero = (m_cnt == 8'h00);
            pwm  = (mode == 2'd1) || (mode == 2'd3);
            n_cnt = m_cnt; n_down = m_down;
            if (cnt_we) n_cnt = cnt_wdata;
            else if (stp) begin
                case (mode)
                    2'd0, 2'd3: n_cnt = m_cnt + 8'd1;
                    2'd2:       n_cnt = mt ? 8'd0 : m_cnt + 8'd1;
                    default: begin
                        if (!m_down) begin
                            if (amax) begin n_cnt = 8'hFE; n_down = 1'b1; end
                            else n_cnt = m_cnt + 8'd1;
                        end else begin
                            if (zero) begin n_cnt = 8'h01; n_down = 1'b0; end
                            else n_cnt = m_cnt - 8'd1;
                        end
                    end
                endcase
            end
            if (mode != 2'd1) n_down = 1'b0;
            n_cf = m_cf;
            if (stp && mt) n_cf = 1'b1;
            else if (ack || (flag_wr && flag_wdata[0])) n_cf = 1'b0;
            ev = stp && ((mode == 2'd1) ? (m_down && zero) : amax);
            n_of = m_of;
            if (ev) n_of = 1'b1;
            else if (flag_wr && flag_wdata[1]) n_of = 1'b0;
            ld = stp && amax && ((mode == 2'd3) || (mode == 2'd1 && !m_down));
            n_act = m_act; n_hold = m_hold;
            if (!pwm && cmp_we) n_act = cmp_wdata;
            else if (pwm && ld) n_act = m_hold;
            if (cmp_we) n_hold = cmp_wdata;
            n_wave = m_wave;
            if (stp) begin
                case (mode)
                    2'd0, 2'd2: if (mt) begin
                        if (out_mode == 2'd1) n_wave = !m_wave;
                        else if (out_mode == 2'd2) n_wave = 1'b0;
                        else if (out_mode == 2'd3) n_wave = 1'b1;
                    end
                    2'd3: begin
                        if (out_mode == 2'd2) n_wave = amax ? 1'b1 : (mt ? 1'b0 : m_wave);
                        else if (out_mode == 2'd3) n_wave = amax ? 1'b0 : (mt ? 1'b1 : m_wave);
                    end
                    default: if (mt) begin
                        if (out_mode == 2'd2) n_wave = m_down;
                        else if (out_mode == 2'd3) n_wave = !m_down;
                    end
                endcase
            end
            m_cnt = n_cnt; m_down = n_down; m_cf = n_cf; m_of = n_of;
            m_act = n_act; m_hold = n_hold; m_wave = n_wave;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare_all();
        logic pwm, off;
        string wl;
        pwm = (mode == 2'd1) || (mode == 2'd3);
        off = (out_mode == 2'd0) || (pwm && out_mode == 2'd1);
        wl  = off ? "R13 pin" : (mode == 2'd3) ? "R11 fast wave" :
              (mode == 2'd1) ? "R12 phase wave" : "R10 match wave";
        chk("R2 count", count, m_cnt);
        chk("R8 cmp_act", cmp_act, m_act);
        chk("R4 cmp_flag", cmp_flag, m_cf);
        chk("R7 ovf_flag", ovf_flag, m_of);
        chk("R6 irq", irq, m_cf && irq_en);
        chk(wl, wave_out, off ? 0 : m_wave);
        chk("R9 at_top", at_top, (mode == 2'd2) ? (m_cnt == m_act) : (m_cnt == 8'hFF));
        chk("R9 at_bottom", at_bottom, m_cnt == 8'h00);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        tick = 0; cnt_we = 0; cmp_we = 0; flag_wr = 0; ack = 0; flag_wdata = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        cyc();
        cyc();
        rst_n = 1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        logic [7:0] cvals [5];
        cvals[0] = 8'h00; cvals[1] = 8'h01; cvals[2] = 8'h7F; cvals[3] = 8'hFE; cvals[4] = 8'hFF;

        // R1: reset state
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 cmp_act", cmp_act, 0);
        chk("R1 flags", {cmp_flag, ovf_flag}, 0);

        // sweep of every mode, pin action, compare value and tick pattern
        for (int om = 0; om < 4; om++)
        for (int md = 0; md < 4; md++)
        for (int ci = 0; ci < 5; ci++)
        for (int tp = 0; tp < 2; tp++) begin
            mode = md[1:0]; out_mode = om[1:0];
            do_reset();
            cmp_we = 1; cmp_wdata = cvals[ci];
            cyc();
            cmp_we = 0;
            for (int n = 0; n < 520; n++) begin
                tick       = tp ? (n % 3 != 2) : 1'b1;
                cnt_we     = (n % 131 == 130);
                cnt_wdata  = n[7:0] ^ 8'hA5;
                cmp_we     = (n == 260);
                cmp_wdata  = cvals[ci] ^ 8'h55;
                flag_wr    = (n % 37 == 36);
                flag_wdata = n[1:0];
                ack        = (n % 53 == 52);
                irq_en     = n[4];
                cyc();
            end
            idle_inputs();
        end

        // R3: counter write collides with an active tick
        mode = 2'd0; out_mode = 2'd0;
        do_reset();
        tick = 1;
        repeat (10) cyc();
        cnt_we = 1; cnt_wdata = 8'h80;
        cyc();
        cnt_we = 0; tick = 0;
        chk("R3 write wins over step", count, 8'h80);
        cyc();
        chk("R3 value held", count, 8'h80);

        // R5: flag clearing by write-one, write-zero and acknowledge
        cmp_we = 1; cmp_wdata = 8'h82;
        cyc();
        cmp_we = 0; tick = 1;
        cyc();
        cyc();
        tick = 0;
        cyc();
        chk("R5 flag set before clears", cmp_flag, 1);
        flag_wr = 1; flag_wdata = 2'b10;
        cyc();
        flag_wr = 0;
        chk("R5 write of 0 leaves compare flag", cmp_flag, 1);
        flag_wr = 1; flag_wdata = 2'b01;
        cyc();
        flag_wr = 0;
        chk("R5 write of 1 clears compare flag", cmp_flag, 0);
        cnt_we = 1; cnt_wdata = 8'h82;
        cyc();
        cnt_we = 0; tick = 1;
        cyc();
        tick = 0;
        chk("R4 flag after match step", cmp_flag, 1);
        ack = 1;
        cyc();
        ack = 0;
        chk("R5 ack clears compare flag", cmp_flag, 0);

        finish_run();
    end
endmodule